// File: doc/BRIEF.md
# HDLC Transmit Byte Pool with Cyclic Repeat

This block buffers outgoing data for one HDLC channel. A host writes payload into a 32-byte pool, either one byte or one 16-bit word per write. A bit-serial transmitter drains the pool one bit per `bit_en` strobe, least significant bit first. Flag insertion, CRC and bit stuffing are left to a framer downstream. When the pool has been fully sent, or has been cleared by a reset command, the block raises a ready interrupt so that the host can refill it.

The host steers the block through a five-bit command port. A plain send command streams the pool once and consumes each byte as it goes. A transparent send combined with the repeat bit starts a cyclic mode instead. In that mode the 1 to 32 stored bytes are sent again and again, with nothing added between passes, and the data stays in the pool. The loop runs until a reset command arrives or until a command is written with the repeat bit clear.

Top module: `hdlc_tx_pool`

## Requirements
- R1: After reset, `tx_valid`, `loop_on`, `pool_ready` and `overflow` are all 0 and the pool is empty.
- R2: Each byte is sent least significant bit first. `tx_bit` holds its value while `tx_valid` is 1, and it advances one bit on each clock edge where `bit_en` is 1.
- R3: The pool holds 32 bytes. A write with `wr_word`=0 stores `wr_data[7:0]`. A write with `wr_word`=1 stores `wr_data[7:0]` and then `wr_data[15:8]`. Bytes leave in the order they were stored.
- R4: In idle, a command with bit 3 (framed send) set, or with bit 2 (transparent send) set and bit 4 (repeat) clear, sends every stored byte once and consumes it. One clock after the last bit has been shifted out, `pool_ready` is set.
- R5: In idle, a command with bit 2 and bit 4 both set and a non-empty pool starts cyclic mode (`loop_on`=1). The stored bytes are sent in order and the sequence wraps after the last byte, without end. The pool contents are not consumed. Further commands that keep bit 4 set do not disturb the loop.
- R6: During cyclic mode, a command with bit 4 clear ends the loop on the next clock edge. Any partly sent byte is dropped and `tx_valid` falls. The stored bytes remain and can be sent afterwards.
- R7: A command with bit 0 (software reset) or bit 1 (transmitter reset) set empties the pool, stops any transmission at once, sets `pool_ready` and clears `overflow`. A data write in the same cycle is dropped.
- R8: A write that does not fit in the remaining space is dropped whole, including both bytes of a word, and sets `overflow`. `overflow` stays set until a reset command.
- R9: `pool_ready` stays set until a cycle with `irq_ack`=1. A set condition in that same cycle wins over the acknowledge.
- R10: A cyclic-start command on an empty pool is ignored, and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Data write strobe |
| wr_word | input | 1 | 1: 16-bit write, 0: byte write |
| wr_data | input | 16 | Write data, low byte first |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 5 | Command bits: 0 soft reset, 1 transmitter reset, 2 transparent send, 3 framed send, 4 repeat |
| irq_ack | input | 1 | Clears `pool_ready` |
| bit_en | input | 1 | Serial bit advance strobe |
| tx_bit | output | 1 | Serial data bit |
| tx_valid | output | 1 | `tx_bit` carries a payload bit |
| loop_on | output | 1 | Cyclic mode is running |
| pool_ready | output | 1 | Ready-for-data interrupt |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
A wrong read pointer or loop index shows up as a wrong byte on `tx_bit` within nine clocks of the load that picked it. In cyclic mode it also shows up as a loop period or byte order that differs from the stored block. A wrong fill count surfaces as `pool_ready` rising too early or too late, or as `overflow` being set on a write that fits or staying clear on one that does not. The bench compares every output against a behavioural model on every clock, so any of these faults is reported in the cycle where it first reaches a port.

// File: rtl/hdlc_txp_pkg.sv
package hdlc_txp_pkg;

  typedef enum logic [1:0] {
    TXP_IDLE = 2'd0,
    TXP_SEND = 2'd1,
    TXP_LOOP = 2'd2
  } txp_state_e;

  // command bit positions (host-visible encoding)
  localparam int CMD_W     = 5;
  localparam int CMD_SWRST = 0;
  localparam int CMD_TXRST = 1;
  localparam int CMD_RAW   = 2;
  localparam int CMD_FRM   = 3;
  localparam int CMD_RPT   = 4;

  // byte lanes in one host word write
  localparam int LANES     = 2;

endpackage

// File: rtl/hdlc_txp_store.sv
module hdlc_txp_store
  import hdlc_txp_pkg::*;
#(
  parameter  int DEPTH = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_word,
  input  logic [8*LANES-1:0]   wr_data,
  input  logic                 flush,
  input  logic                 pop,
  input  logic [AW-1:0]        rd_off,
  output logic [7:0]           rd_byte,
  output logic [CW-1:0]        count,
  output logic                 ovf
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q, count_d;
  logic          ovf_q, ovf_d;
  logic [CW:0]   room_need;
  logic          accept, reject;

  function automatic logic [AW-1:0] wrap_add(input logic [AW-1:0] p,
                                             input logic [AW-1:0] s);
    logic [AW:0] t;
    t = {1'b0, p} + {1'b0, s};
    if (t >= (AW+1)'(DEPTH)) t = t - (AW+1)'(DEPTH);
    return t[AW-1:0];
  endfunction

  // admission: the whole write fits or nothing is stored
  always_comb begin
    room_need = {1'b0, count_q} + (wr_word ? (CW+1)'(2) : (CW+1)'(1));
    accept    = wr_en && !flush && (room_need <= (CW+1)'(DEPTH));
    reject    = wr_en && !flush && !accept;
  end

  // per-lane write enables and addresses
  logic          lane_we   [LANES];
  logic [AW-1:0] lane_addr [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_we[l]   = accept && ((l == 0) || wr_word);
    assign lane_addr[l] = wrap_add(wr_ptr_q, AW'(l));
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (lane_we[l]) mem[lane_addr[l]] <= wr_data[8*l +: 8];
    end
  end

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    ovf_d    = ovf_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
      ovf_d    = 1'b0;
    end else begin
      if (accept) begin
        wr_ptr_d = wrap_add(wr_ptr_q, wr_word ? AW'(2) : AW'(1));
        count_d  = room_need[CW-1:0];
      end
      if (pop) begin
        rd_ptr_d = wrap_add(rd_ptr_q, AW'(1));
        count_d  = count_d - CW'(1);
      end
      if (reject) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
      ovf_q    <= ovf_d;
    end
  end

  assign rd_byte = mem[wrap_add(rd_ptr_q, rd_off)];
  assign count   = count_q;
  assign ovf     = ovf_q;

  // R3: fill never exceeds capacity
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));

  // R8: a write into a full pool leaves the fill unchanged and flags it
  a_r8_full_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush && !pop && count_q == CW'(DEPTH))
      |=> (count_q == $past(count_q)) && ovf_q);

  // R8: overflow is sticky until a flush
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !flush) |=> ovf_q);

endmodule

// File: rtl/hdlc_txp_ctrl.sv
module hdlc_txp_ctrl
  import hdlc_txp_pkg::*;
#(
  parameter  int DEPTH = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd,
  input  logic             irq_ack,
  input  logic [CW-1:0]    count,
  input  logic             ser_empty,
  output logic             flush,
  output logic             ser_clr,
  output logic             ld,
  output logic             pop,
  output logic [AW-1:0]    rd_off,
  output logic             loop_on,
  output logic             irq
);

  txp_state_e    st_q, st_d;
  logic [AW-1:0] lp_q, lp_d;
  logic          irq_q, irq_d;
  logic          rst_cmd, stop_cmd, loop_cmd, plain_cmd, has_data, done;
  logic [CW-1:0] lp_nx;

  always_comb begin
    rst_cmd   = cmd_we && (cmd[CMD_SWRST] || cmd[CMD_TXRST]);
    loop_cmd  = cmd[CMD_RAW] && cmd[CMD_RPT];
    plain_cmd = (cmd[CMD_RAW] || cmd[CMD_FRM]) && !loop_cmd;
    stop_cmd  = cmd_we && !rst_cmd && (st_q == TXP_LOOP) && !cmd[CMD_RPT];
    has_data  = (count != '0);
    flush     = rst_cmd;
    ser_clr   = rst_cmd || stop_cmd;
    ld        = !ser_clr && ser_empty && (st_q != TXP_IDLE) && has_data;
    pop       = ld && (st_q == TXP_SEND);
    done      = !ser_clr && (st_q == TXP_SEND) && ser_empty && !has_data;
    rd_off    = (st_q == TXP_LOOP) ? lp_q : '0;
    lp_nx     = CW'(lp_q) + CW'(1);
  end

  always_comb begin
    st_d  = st_q;
    lp_d  = lp_q;
    irq_d = irq_q;
    if (ser_clr) begin
      st_d = TXP_IDLE;
      lp_d = '0;
    end else if (st_q == TXP_IDLE && cmd_we && loop_cmd && has_data) begin
      st_d = TXP_LOOP;
      lp_d = '0;
    end else if (st_q == TXP_IDLE && cmd_we && plain_cmd) begin
      st_d = TXP_SEND;
    end else if (done) begin
      st_d = TXP_IDLE;
    end else if (ld && st_q == TXP_LOOP) begin
      lp_d = (lp_nx >= count) ? '0 : lp_q + AW'(1);
    end
    if (rst_cmd || done) irq_d = 1'b1;
    else if (irq_ack)    irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TXP_IDLE;
      lp_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      lp_q  <= lp_d;
      irq_q <= irq_d;
    end
  end

  assign loop_on = (st_q == TXP_LOOP);
  assign irq     = irq_q;

  // R7: a reset command leaves the block idle with the interrupt raised
  a_r7_reset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd |=> (st_q == TXP_IDLE) && irq_q);

  // R9: interrupt holds until acknowledged
  a_r9_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_ack) |=> irq_q);

  // R6: a command without the repeat bit ends the loop
  a_r6_loop_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TXP_LOOP && cmd_we && !cmd[CMD_RPT]) |=> (st_q == TXP_IDLE));

  // R10: no loop on an empty pool
  a_r10_no_empty_loop: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TXP_IDLE && cmd_we && count == '0) |=> (st_q != TXP_LOOP));

endmodule

// File: rtl/hdlc_txp_ser.sv
module hdlc_txp_ser #(
  parameter  int W  = 8,
  localparam int NW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         bit_en,
  output logic         tx_bit,
  output logic         tx_valid,
  output logic         empty
);

  logic [W-1:0]  sh_q, sh_d;
  logic [NW-1:0] n_q, n_d;

  always_comb begin
    sh_d = sh_q;
    n_d  = n_q;
    if (clr) begin
      n_d = '0;
    end else if (load) begin
      sh_d = din;
      n_d  = NW'(W);
    end else if (n_q != '0 && bit_en) begin
      sh_d = {1'b0, sh_q[W-1:1]};
      n_d  = n_q - NW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      n_q  <= '0;
    end else begin
      sh_q <= sh_d;
      n_q  <= n_d;
    end
  end

  assign tx_bit   = sh_q[0];
  assign tx_valid = (n_q != '0);
  assign empty    = (n_q == '0);

  // R2: without a strobe the current bit is held
  a_r2_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !bit_en && !clr) |=> $stable(tx_bit) && tx_valid);

  // R2: a load presents a payload bit on the next cycle
  a_r2_load_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> tx_valid);

endmodule

// File: rtl/hdlc_tx_pool.sv
module hdlc_tx_pool
  import hdlc_txp_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_word,
  input  logic [15:0]      wr_data,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic             irq_ack,
  input  logic             bit_en,
  output logic             tx_bit,
  output logic             tx_valid,
  output logic             loop_on,
  output logic             pool_ready,
  output logic             overflow
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic          flush, ser_clr, ld, pop, ser_empty;
  logic [AW-1:0] rd_off;
  logic [7:0]    rd_byte;
  logic [CW-1:0] fill;

  hdlc_txp_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_word (wr_word),
    .wr_data (wr_data),
    .flush   (flush),
    .pop     (pop),
    .rd_off  (rd_off),
    .rd_byte (rd_byte),
    .count   (fill),
    .ovf     (overflow)
  );

  hdlc_txp_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (cmd_we),
    .cmd       (cmd_data),
    .irq_ack   (irq_ack),
    .count     (fill),
    .ser_empty (ser_empty),
    .flush     (flush),
    .ser_clr   (ser_clr),
    .ld        (ld),
    .pop       (pop),
    .rd_off    (rd_off),
    .loop_on   (loop_on),
    .irq       (pool_ready)
  );

  hdlc_txp_ser #(.W(8)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ser_clr),
    .load     (ld),
    .din      (rd_byte),
    .bit_en   (bit_en),
    .tx_bit   (tx_bit),
    .tx_valid (tx_valid),
    .empty    (ser_empty)
  );

  // R5: while looping with no host activity the pool fill is unchanged
  a_r5_loop_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_on && !wr_en && !cmd_we) |=> $stable(fill));

endmodule

// File: tb/hdlc_tx_pool_tb.sv
module hdlc_tx_pool_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_word, cmd_we, irq_ack, bit_en;
  logic [15:0] wr_data;
  logic [4:0]  cmd_data;
  logic        tx_bit, tx_valid, loop_on, pool_ready, overflow;

  int n_chk = 0;
  int n_bad = 0;
  bit gate  = 0;
  bit over  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_tx_pool u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
    .wr_data(wr_data), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .irq_ack(irq_ack), .bit_en(bit_en), .tx_bit(tx_bit),
    .tx_valid(tx_valid), .loop_on(loop_on), .pool_ready(pool_ready),
    .overflow(overflow)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_q[$];
  int         m_st, m_lp, m_bits;
  logic [7:0] m_sh;
  bit         m_irq, m_ovf;

  always @(posedge clk) begin : model
    int cnt, n;
    bit rc, stp, ld, dn, acc, lpc, plc;
    logic [7:0] b;
    if (!rst_n) begin
      m_q.delete(); m_st = 0; m_lp = 0; m_bits = 0; m_sh = 0;
      m_irq = 0; m_ovf = 0;
    end else begin
      cnt = m_q.size();
      rc  = cmd_we && (cmd_data[0] || cmd_data[1]);
      lpc = cmd_data[2] && cmd_data[4];
      plc = (cmd_data[2] || cmd_data[3]) && !lpc;
      stp = cmd_we && !rc && m_st == 2 && !cmd_data[4];
      ld  = !(rc || stp) && m_bits == 0 && m_st != 0 && cnt > 0;
      dn  = !(rc || stp) && m_st == 1 && m_bits == 0 && cnt == 0;
      b   = 8'h00;
      if (ld) b = (m_st == 1) ? m_q[0] : m_q[m_lp];
      n   = wr_word ? 2 : 1;
      acc = wr_en && !rc && (cnt + n <= 32);
      if (rc) m_q.delete();
      else begin
        if (ld && m_st == 1) void'(m_q.pop_front());
        if (acc) begin
          m_q.push_back(wr_data[7:0]);
          if (wr_word) m_q.push_back(wr_data[15:8]);
        end
      end
      if (rc) m_ovf = 0;
      else if (wr_en && !acc) m_ovf = 1;
      if (rc || stp) m_bits = 0;
      else if (ld) begin m_sh = b; m_bits = 8; end
      else if (m_bits != 0 && bit_en) begin m_sh = m_sh >> 1; m_bits--; end
      if (rc || dn) m_irq = 1;
      else if (irq_ack) m_irq = 0;
      if (rc || stp) begin m_st = 0; m_lp = 0; end
      else if (m_st == 0 && cmd_we && lpc && cnt > 0) begin m_st = 2; m_lp = 0; end
      else if (m_st == 0 && cmd_we && plc) m_st = 1;
      else if (dn) m_st = 0;
      else if (ld && m_st == 2) m_lp = (m_lp + 1 >= cnt) ? 0 : m_lp + 1;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !over) begin
      chk(tx_valid == (m_bits != 0), "R4 tx_valid", int'(tx_valid), int'(m_bits != 0));
      if (m_bits != 0) chk(tx_bit == m_sh[0], "R2 tx_bit", int'(tx_bit), int'(m_sh[0]));
      chk(loop_on == (m_st == 2), "R5 loop_on", int'(loop_on), int'(m_st == 2));
      chk(pool_ready == m_irq, "R9 pool_ready", int'(pool_ready), int'(m_irq));
      chk(overflow == m_ovf, "R8 overflow", int'(overflow), int'(m_ovf));
    end
  end

  // bit_en pattern
  always @(negedge clk) bit_en <= gate ? (($urandom % 3) != 0) : 1'b1;

  // serial receiver (reads pre-update values at the edge)
  logic [7:0] rx_q[$];
  logic [7:0] rx_sh;
  int         rx_n = 0;
  always @(posedge clk) begin
    if (rst_n && tx_valid && bit_en) begin
      rx_sh = {tx_bit, rx_sh[7:1]};
      rx_n++;
      if (rx_n == 8) begin rx_q.push_back(rx_sh); rx_n = 0; end
    end
  end

  task automatic clear_rx();
    rx_q.delete(); rx_n = 0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_b(input logic [7:0] b);
    @(negedge clk); wr_en = 1; wr_word = 0; wr_data = {8'h00, b};
    @(negedge clk); wr_en = 0;
  endtask

  task automatic put_w(input logic [15:0] w);
    @(negedge clk); wr_en = 1; wr_word = 1; wr_data = w;
    @(negedge clk); wr_en = 0; wr_word = 0;
  endtask

  task automatic do_cmd(input logic [4:0] c, input bit ack = 0);
    @(negedge clk); cmd_we = 1; cmd_data = c; irq_ack = ack;
    @(negedge clk); cmd_we = 0; cmd_data = 0; irq_ack = 0;
  endtask

  task automatic do_ack();
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask

  task automatic wait_irq(input int lim);
    int k = 0;
    while (!pool_ready && k < lim) begin @(negedge clk); k++; end
  endtask

  task automatic check_stream(input string tag, input logic [7:0] e[$]);
    chk(rx_q.size() == e.size(), {tag, " length"}, rx_q.size(), e.size());
    for (int i = 0; i < e.size() && i < rx_q.size(); i++)
      chk(rx_q[i] == e[i], {tag, " byte"}, int'(rx_q[i]), int'(e[i]));
  endtask

  task automatic finish_run();
    over = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] e[$];
    logic [7:0] pat[$];
    rst_n = 0; wr_en = 0; wr_word = 0; wr_data = 0;
    cmd_we = 0; cmd_data = 0; irq_ack = 0;
    tick(3);
    rst_n = 1;
    tick(1);
    // R1 reset state
    chk(!tx_valid && !loop_on, "R1 idle outputs", int'({tx_valid, loop_on}), 0);
    chk(!pool_ready && !overflow, "R1 flags clear", int'({pool_ready, overflow}), 0);

    // R3/R4: byte then word, low byte first, framed send
    clear_rx();
    put_b(8'h35);
    put_w(16'hA1B2);
    do_cmd(5'h08);
    wait_irq(500);
    chk(pool_ready, "R4 ready after send", int'(pool_ready), 1);
    e = '{8'h35, 8'hB2, 8'hA1};
    check_stream("R2 R3 word order", e);
    do_ack();
    chk(!pool_ready, "R9 ack clears", int'(pool_ready), 0);

    // R3/R8: fill all 32 bytes, then overflow, random strobes
    clear_rx();
    gate = 1;
    e.delete();
    for (int i = 0; i < 16; i++) begin
      put_w({8'(2*i+1), 8'(2*i)});
      e.push_back(8'(2*i)); e.push_back(8'(2*i+1));
    end
    chk(!overflow, "R8 no overflow at 32", int'(overflow), 0);
    put_b(8'hEE);
    chk(overflow, "R8 overflow on byte", int'(overflow), 1);
    put_w(16'hEEEE);
    do_cmd(5'h04);
    wait_irq(4000);
    check_stream("R3 full pool", e);
    chk(overflow, "R8 overflow sticky", int'(overflow), 1);
    do_cmd(5'h01);
    chk(!overflow, "R7 reset clears overflow", int'(overflow), 0);
    chk(pool_ready, "R7 reset sets ready", int'(pool_ready), 1);
    gate = 0;
    do_ack();

    // R5/R6: cyclic mode of three bytes
    pat = '{8'h5A, 8'h0F, 8'h81};
    foreach (pat[i]) put_b(pat[i]);
    clear_rx();
    do_cmd(5'h14);
    tick(100);
    chk(loop_on, "R5 loop running", int'(loop_on), 1);
    chk(rx_q.size() >= 9, "R5 loop repeats", rx_q.size(), 9);
    for (int i = 0; i < rx_q.size(); i++)
      chk(rx_q[i] == pat[i % 3], "R5 loop byte", int'(rx_q[i]), int'(pat[i % 3]));
    do_cmd(5'h14);
    chk(loop_on, "R5 repeat bit keeps loop", int'(loop_on), 1);
    do_cmd(5'h04);
    chk(!tx_valid && !loop_on, "R6 loop stopped", int'({tx_valid, loop_on}), 0);
    clear_rx();
    do_cmd(5'h08);
    wait_irq(500);
    check_stream("R6 data kept", pat);
    do_ack();

    // R10: loop on empty pool
    do_cmd(5'h01);
    do_ack();
    do_cmd(5'h14);
    tick(3);
    chk(!loop_on && !tx_valid, "R10 empty loop ignored", int'({loop_on, tx_valid}), 0);

    // R7: transmitter reset during a 32-byte loop
    for (int i = 0; i < 16; i++) put_w({8'(6*i+3), 8'(6*i)});
    do_cmd(5'h14);
    tick(20);
    do_cmd(5'h02);
    chk(!tx_valid && !loop_on, "R7 tx reset stops", int'({tx_valid, loop_on}), 0);
    chk(pool_ready, "R7 tx reset sets ready", int'(pool_ready), 1);
    do_ack();
    clear_rx();
    do_cmd(5'h08);
    wait_irq(50);
    chk(pool_ready, "R7 empty send completes", int'(pool_ready), 1);
    chk(rx_q.size() == 0, "R7 pool emptied", rx_q.size(), 0);

    // R9: set wins over acknowledge
    do_ack();
    chk(!pool_ready, "R9 ack clears", int'(pool_ready), 0);
    do_cmd(5'h01, 1);
    chk(pool_ready, "R9 set wins over ack", int'(pool_ready), 1);
    do_ack();

    // R5: one-byte loop with irregular strobes
    put_b(8'hC3);
    clear_rx();
    gate = 1;
    do_cmd(5'h14);
    tick(150);
    chk(rx_q.size() >= 3, "R5 single byte loop", rx_q.size(), 3);
    foreach (rx_q[i]) chk(rx_q[i] == 8'hC3, "R5 single byte value", int'(rx_q[i]), 8'hC3);
    do_cmd(5'h01);
    gate = 0;
    chk(!loop_on, "R7 soft reset ends loop", int'(loop_on), 0);

    tick(5);
    finish_run();
  end

endmodule